// File: doc/BRIEF.md
# Binary to Blanked Decimal Text Line Streamer

This block turns a 32-bit unsigned number into one fixed-length line of ASCII text and hands the line out one byte at a time, in a form that a serial transmitter can take directly. A single-cycle start pulse captures the value. The block then converts it to decimal in hardware by repeated subtraction of powers of ten. Only after the conversion is complete does it begin to present characters on a valid/ready byte handshake.

The line is 14 characters long and its layout is fixed. It opens with a one-letter tag, 'S'. Four spaces of padding follow. The line ends with a nine-digit decimal field, most significant digit first. Leading zeros in that field are shown as spaces, so the number appears right-aligned.

A value of one thousand million or more is first reduced modulo 10^9, which keeps the field at exactly nine digits. A start pulse that arrives while a line is still in progress has no effect.

Top module: `dec_line_streamer`

## Requirements
- R1: While reset is high and on the cycle after it, `busy_o` and `byte_valid_o` are both low.
- R2: Each line is exactly 14 accepted bytes. Byte 0 is 0x53 ('S') and bytes 1 to 4 are 0x20.
- R3: Bytes 5 to 13 carry the decimal digits from the 10^8 place down to the units place. A digit d is sent as 0x30+d once the field has shown a nonzero digit.
- R4: A zero digit that comes before the first nonzero digit is sent as 0x20. A zero that comes after it is sent as 0x30.
- R5: A value of zero gives nine 0x20 bytes in the digit field, the units position included.
- R6: While `byte_valid_o` is high and `byte_ready_i` is low, the next cycle keeps `byte_valid_o` high and `byte_o` unchanged. A byte is consumed only on a cycle where both are high.
- R7: `busy_o` rises on the cycle after an accepted start and stays high until the last byte is accepted. It is low on the following cycle. `byte_valid_o` is never high while `busy_o` is low.
- R8: A value of 1,000,000,000 or more is shown as the value modulo 10^9.
- R9: A start pulse while `busy_o` is high is ignored. The line in progress continues with the original value, and no extra line follows it.
- R10: Every presented byte is one of 0x53, 0x20 or 0x30 to 0x39.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | One-cycle request to format `value_i` |
| value_i | input | 32 | Unsigned binary value, sampled with `start_i` |
| busy_o | output | 1 | High while a line is being converted or sent |
| byte_o | output | 8 | Current ASCII character |
| byte_valid_o | output | 1 | `byte_o` holds a character to take |
| byte_ready_i | input | 1 | Downstream takes `byte_o` this cycle when valid |

## Verification
The bench sweeps every value from 0 to 299. This sweep covers the all-blank field, single digits and the change from blank to '0' inside the field. It also runs each power of ten and each power of ten minus one up to 10^9. These show whether blanking stops at the first nonzero digit, whether it stops only there, and whether inner zeros print as '0'. Values at 10^9 and above, up to 0xFFFFFFFF, separate true modulo reduction from plain truncation or a carry into the top digit. Ready patterns run from always-ready to sparse, and some runs inject a start mid-line, so that stalls, held bytes and ignored restarts are each seen on their own.

// File: rtl/dls_pkg.sv
package dls_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_CONV,
    ST_SEND
  } seq_state_t;

  localparam logic [7:0] ASCII_SPACE = 8'h20;
  localparam logic [7:0] ASCII_ZERO  = 8'h30;

  // 10 raised to n, exact for n up to 19
  function automatic logic [63:0] pow10(input int n);
    logic [63:0] acc;
    acc = 64'd1;
    for (int i = 0; i < n; i++) acc = acc * 64'd10;
    return acc;
  endfunction

endpackage

// File: rtl/dls_sub_conv.sv
module dls_sub_conv #(
  parameter int WIDTH  = 32,
  parameter int DIGITS = 9
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   load_i,
  input  logic [WIDTH-1:0]       value_i,
  output logic                   done_o,
  output logic [DIGITS-1:0][3:0] digits_o
);
  import dls_pkg::*;

  localparam int PW = $clog2(DIGITS + 1);

  logic [WIDTH-1:0]       rem_q;
  logic [PW-1:0]          place_q;
  logic [3:0]             cnt_q;
  logic                   run_q;
  logic                   done_q;
  logic [DIGITS-1:0][3:0] dig_q;
  logic [63:0]            weight;
  logic                   fits;

  // place DIGITS is the discarded overflow place: it implements modulo 10^DIGITS
  assign weight = pow10(int'(place_q));
  assign fits   = 64'(rem_q) >= weight;

  always_ff @(posedge clk) begin
    if (rst) begin
      rem_q   <= '0;
      place_q <= '0;
      cnt_q   <= '0;
      run_q   <= 1'b0;
      done_q  <= 1'b0;
      dig_q   <= '0;
    end else if (load_i) begin
      rem_q   <= value_i;
      place_q <= PW'(DIGITS);
      cnt_q   <= '0;
      run_q   <= 1'b1;
      done_q  <= 1'b0;
    end else if (run_q) begin
      if (fits) begin
        rem_q <= rem_q - weight[WIDTH-1:0];
        cnt_q <= cnt_q + 4'd1;
      end else begin
        if (place_q != PW'(DIGITS)) dig_q[place_q] <= cnt_q;
        cnt_q <= '0;
        if (place_q == '0) begin
          run_q  <= 1'b0;
          done_q <= 1'b1;
        end else begin
          place_q <= place_q - 1'b1;
        end
      end
    end
  end

  assign done_o   = done_q;
  assign digits_o = dig_q;

endmodule

// File: rtl/dls_char_fmt.sv
module dls_char_fmt #(
  parameter int         DIGITS = 9,
  parameter int         PAD    = 4,
  parameter logic [7:0] TAG    = 8'h53,
  parameter int         LINE   = 1 + PAD + DIGITS,
  parameter int         IW     = $clog2(LINE)
) (
  input  logic [IW-1:0]          idx_i,
  input  logic [DIGITS-1:0][3:0] digits_i,
  output logic [7:0]             ch_o
);
  import dls_pkg::*;

  always_comb begin
    int  place;
    logic seen;
    ch_o  = ASCII_SPACE;
    place = 0;
    seen  = 1'b0;
    if (int'(idx_i) == 0) begin
      ch_o = TAG;
    end else if (int'(idx_i) > PAD) begin
      place = DIGITS - 1 - (int'(idx_i) - PAD - 1);
      for (int k = 0; k < DIGITS; k++) begin
        if (k >= place && digits_i[k] != 4'd0) seen = 1'b1;
      end
      for (int k = 0; k < DIGITS; k++) begin
        if (k == place && seen) ch_o = ASCII_ZERO | {4'd0, digits_i[k]};
      end
    end
  end

endmodule

// File: rtl/dec_line_streamer.sv
module dec_line_streamer #(
  parameter int         WIDTH  = 32,
  parameter int         DIGITS = 9,
  parameter int         PAD    = 4,
  parameter logic [7:0] TAG    = 8'h53
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_i,
  input  logic [WIDTH-1:0] value_i,
  output logic             busy_o,
  output logic [7:0]       byte_o,
  output logic             byte_valid_o,
  input  logic             byte_ready_i
);
  import dls_pkg::*;

  localparam int LINE = 1 + PAD + DIGITS;
  localparam int IW   = $clog2(LINE);

  seq_state_t             state_q;
  logic [IW-1:0]          idx_q;
  logic [7:0]             byte_q;
  logic                   valid_q;
  logic                   conv_load;
  logic                   conv_done;
  logic [DIGITS-1:0][3:0] digits;
  logic [IW-1:0]          fmt_idx;
  logic [7:0]             fmt_ch;
  logic                   accept;

  assign conv_load = (state_q == ST_IDLE) && start_i;
  assign accept    = valid_q && byte_ready_i;
  assign fmt_idx   = (state_q == ST_SEND) ? idx_q + 1'b1 : '0;

  dls_sub_conv #(.WIDTH(WIDTH), .DIGITS(DIGITS)) u_conv (
    .clk      (clk),
    .rst      (rst),
    .load_i   (conv_load),
    .value_i  (value_i),
    .done_o   (conv_done),
    .digits_o (digits)
  );

  dls_char_fmt #(.DIGITS(DIGITS), .PAD(PAD), .TAG(TAG), .LINE(LINE), .IW(IW)) u_fmt (
    .idx_i    (fmt_idx),
    .digits_i (digits),
    .ch_o     (fmt_ch)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
      byte_q  <= '0;
      valid_q <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (start_i) state_q <= ST_CONV;
        ST_CONV: if (conv_done) begin
          state_q <= ST_SEND;
          idx_q   <= '0;
          byte_q  <= fmt_ch;
          valid_q <= 1'b1;
        end
        ST_SEND: if (accept) begin
          if (idx_q == IW'(LINE - 1)) begin
            valid_q <= 1'b0;
            state_q <= ST_IDLE;
          end else begin
            idx_q  <= idx_q + 1'b1;
            byte_q <= fmt_ch;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o       = (state_q != ST_IDLE);
  assign byte_o       = byte_q;
  assign byte_valid_o = valid_q;

endmodule

// File: rtl/dls_checker.sv
module dls_checker (
  input logic       clk,
  input logic       rst,
  input logic       start_i,
  input logic       busy_o,
  input logic [7:0] byte_o,
  input logic       byte_valid_o,
  input logic       byte_ready_i
);

  a_r1_reset_quiet: assert property (@(posedge clk)
    rst |=> (!busy_o && !byte_valid_o));

  a_r6_hold_on_stall: assert property (@(posedge clk) disable iff (rst)
    (byte_valid_o && !byte_ready_i) |=> (byte_valid_o && $stable(byte_o)));

  a_r7_valid_within_busy: assert property (@(posedge clk) disable iff (rst)
    byte_valid_o |-> busy_o);

  a_r9_start_while_busy: assert property (@(posedge clk) disable iff (rst)
    (busy_o && start_i && !byte_valid_o) |=> busy_o);

  a_r10_char_set: assert property (@(posedge clk) disable iff (rst)
    byte_valid_o |-> (byte_o == 8'h53 || byte_o == 8'h20 ||
                      (byte_o >= 8'h30 && byte_o <= 8'h39)));

endmodule

bind dec_line_streamer dls_checker u_chk (
  .clk          (clk),
  .rst          (rst),
  .start_i      (start_i),
  .busy_o       (busy_o),
  .byte_o       (byte_o),
  .byte_valid_o (byte_valid_o),
  .byte_ready_i (byte_ready_i)
);

// File: tb/tb_dec_line_streamer.sv
module tb_dec_line_streamer;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start_i = 1'b0;
  logic [31:0] value_i = '0;
  logic        busy_o;
  logic [7:0]  byte_o;
  logic        byte_valid_o;
  logic        byte_ready_i = 1'b0;

  int n_vec  = 0;
  int n_fail = 0;
  int cycles = 0;
  logic [7:0] exp_q [14];
  logic [15:0] lfsr = 16'hACE1;

  always #10 clk = ~clk;

  dec_line_streamer dut (
    .clk(clk), .rst(rst), .start_i(start_i), .value_i(value_i),
    .busy_o(busy_o), .byte_o(byte_o), .byte_valid_o(byte_valid_o),
    .byte_ready_i(byte_ready_i)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    lfsr   <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    if (cycles == 200000) begin
      n_fail = n_fail + 1;
      $display("FAIL watchdog: run did not finish, actual %0d cycles expected fewer", cycles);
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
      $finish;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic build(input logic [31:0] v);
    longint m;
    longint w;
    int     d;
    bit     seen;
    m = longint'(v) % 64'd1000000000;
    exp_q[0] = 8'h53;
    for (int i = 1; i <= 4; i++) exp_q[i] = 8'h20;
    w = 100000000;
    seen = 1'b0;
    for (int i = 0; i < 9; i++) begin
      d = int'((m / w) % 10);
      if (d != 0) seen = 1'b1;
      exp_q[5+i] = seen ? 8'(8'h30 + d) : 8'h20;
      w = w / 10;
    end
  endtask

  task automatic run_line(input logic [31:0] v, input int mode, input bit inject);
    int         got;
    int         cyc;
    bit         stall;
    bit         r;
    bit         injected;
    logic [7:0] prev;
    string      req;
    build(v);
    @(negedge clk); start_i = 1'b1; value_i = v;
    @(negedge clk); start_i = 1'b0; value_i = ~v;
    check("R7 busy after start", 32'(busy_o), 32'd1);
    got = 0; cyc = 0; stall = 1'b0; injected = 1'b0; prev = '0;
    while (got < 14) begin
      @(negedge clk);
      if (stall) begin
        check("R6 valid held", 32'(byte_valid_o), 32'd1);
        check("R6 byte held", 32'(byte_o), 32'(prev));
      end
      case (mode)
        0: r = 1'b1;
        1: r = cyc[0];
        2: r = (cyc % 3) == 2;
        default: r = lfsr[0];
      endcase
      if (inject && got == 3 && !injected) begin
        start_i  = 1'b1;
        value_i  = v ^ 32'h1234_5678;
        injected = 1'b1;
      end else begin
        start_i = 1'b0;
      end
      byte_ready_i = r;
      if (byte_valid_o && r) begin
        if (got == 0 || got <= 4) req = "R2 prefix";
        else if (v >= 32'd1000000000) req = "R8 modulo";
        else if (v == 32'd0) req = "R5 zero value";
        else if (exp_q[got] == 8'h20) req = "R4 blanking";
        else req = "R3 digit";
        if (inject) req = {req, " R9"};
        check(req, 32'(byte_o), 32'(exp_q[got]));
        got++;
        stall = 1'b0;
      end else begin
        stall = byte_valid_o;
      end
      prev = byte_o;
      cyc++;
    end
    @(negedge clk);
    byte_ready_i = 1'b0;
    start_i = 1'b0;
    check("R7 busy low after line", 32'(busy_o), 32'd0);
    check("R2 no 15th byte", 32'(byte_valid_o), 32'd0);
    repeat (2) @(negedge clk);
    check("R9 no extra line", 32'({busy_o, byte_valid_o}), 32'd0);
  endtask

  initial begin
    logic [31:0] p;
    repeat (3) @(negedge clk);
    check("R1 busy in reset", 32'(busy_o), 32'd0);
    check("R1 valid in reset", 32'(byte_valid_o), 32'd0);
    rst = 1'b0;
    @(negedge clk);
    check("R1 quiet after reset", 32'({busy_o, byte_valid_o}), 32'd0);

    for (int v = 0; v < 300; v++) run_line(32'(v), v % 4, 1'b0);

    p = 32'd10;
    for (int k = 1; k <= 9; k++) begin
      run_line(p, k % 4, 1'b0);
      run_line(p - 32'd1, (k + 1) % 4, 1'b0);
      run_line(p + 32'd7, 3, 1'b0);
      p = p * 32'd10;
    end
    run_line(32'd999999999, 2, 1'b0);
    run_line(32'd1000000000, 0, 1'b0);
    run_line(32'd1000000007, 1, 1'b0);
    run_line(32'd2123456789, 3, 1'b0);
    run_line(32'hFFFF_FFFF, 2, 1'b0);
    run_line(32'd4000000000, 0, 1'b0);
    run_line(32'd90807060, 0, 1'b0);

    run_line(32'd0, 1, 1'b1);
    run_line(32'd12, 0, 1'b1);
    run_line(32'd305000417, 2, 1'b1);
    run_line(32'd3999999999, 3, 1'b1);

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    $finish;
  end

endmodule